// File: doc/BRIEF.md
# I2S Receive Deserializer

This block turns a serial audio stream back into parallel samples. A bit-clock rising edge, already reduced to a one-cycle strobe in the system clock domain, samples word select and serial data together. The block finds channel boundaries from word-select transitions. It shifts each slot in MSB first and hands complete samples to a downstream consumer over a valid/ready pair. Two framings are handled, selected by `fmt_lj`: standard I2S and left-justified. Eight word-length codes are supported, two of which pack a left/right pair into one output word. The block also has a mono option that repeats the left sample as the right one, and a loopback option that listens to the local transmit line instead of the external data pin.

Control is a four-state machine. `ST_OFF` is held while `enable` is low. Raising `enable` moves `ST_OFF` to `ST_HUNT`. `ST_HUNT` waits for the start of a left slot and ignores all other bits. When a left slot opens, `ST_HUNT` moves to `ST_LEFT`. From `ST_LEFT` or `ST_RIGHT`, each new slot start moves the machine to the state of that slot's channel, `ST_LEFT` or `ST_RIGHT`. Dropping `enable` returns any state to `ST_OFF`.

The configuration inputs (`fmt_lj`, `len_code`, `rx_mono`, `loopback`) are expected to change only while `enable` is low and the output holds no word.

Top module: `i2s_rx_deser`

## Requirements
- R1: Left-justified framing (`fmt_lj`=1): `ws` high marks the left channel. The bit sampled on the same strobe at which `ws` changes level is the MSB of the new slot.
- R2: I2S framing (`fmt_lj`=0): `ws` low marks the left channel. The MSB of a slot is the bit sampled on the strobe after the one at which `ws` changed. The bit sampled on the change strobe still belongs to the previous slot.
- R3: `len_code` selects the sample length: 0→32, 1→24, 2→20, 3→18, 4→16, 5→16 packed, 6→8, 7→8 packed bits. Bits arriving in a slot after the sample length are discarded. Unpacked samples appear right-aligned in `out_data` with zeros above.
- R4: In packed modes, one word is produced per frame, after the right slot. Code 5 puts the left sample in bits 15:0 and the right sample in bits 31:16. Code 7 puts the left sample in bits 7:0, the right sample in bits 15:8, and zeros in bits 31:16. `out_right` is 0 for packed words. For unpacked words, `out_right` is 0 for left and 1 for right.
- R5: With `rx_mono`=1, the word delivered for the right channel carries the left sample of the same frame. In packed modes, both halves carry the left sample.
- R6: With `loopback`=1, serial data is taken from `sd_tx` and `sd_pin` has no effect. With `loopback`=0, data is taken from `sd_pin`.
- R7: After `enable` rises, nothing is delivered until a left slot opens. Partial left and right slots that were in progress when the block was enabled are dropped.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` stays high, and `out_data`/`out_right` hold their value unless a new sample completes.
- R9: A sample that completes while an unaccepted word is held replaces that word, and `overrun` pulses high for one cycle. `overrun` never rises otherwise.
- R10: While `enable` is low, no new word is produced, including for a slot that was in progress when `enable` fell.
- R11: Out of reset, `out_valid` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver enable |
| fmt_lj | input | 1 | 1: left-justified framing, 0: I2S framing |
| len_code | input | 3 | Sample length code (see R3) |
| rx_mono | input | 1 | Repeat left sample as right |
| loopback | input | 1 | Take serial data from `sd_tx` |
| bit_stb | input | 1 | One-cycle strobe marking a bit-clock rising edge |
| ws | input | 1 | Word select, sampled on `bit_stb` |
| sd_pin | input | 1 | External serial data |
| sd_tx | input | 1 | Local transmit serial data (loopback source) |
| out_ready | input | 1 | Consumer accepts `out_data` |
| out_valid | output | 1 | `out_data` holds a word |
| out_data | output | 32 | Received sample or packed pair |
| out_right | output | 1 | Word is an unpacked right-channel sample |
| overrun | output | 1 | One-cycle pulse: held word was replaced |

## Verification
The main capture path is driven with both framings and every length code. Slot widths range from one equal to the sample length (the I2S last bit then lands after the word-select change) up to wider slots whose trailing bits are driven as ones. Together these show whether the MSB position, the discard of excess bits, and the zero fill are all correct. Packed and mono streams use distinct left and right values, so swapped halves or a missing left copy show up as mismatches. Each stream opens with a long partial left slot while already enabled, which exposes any capture that starts before the first real left slot. In loopback runs `sd_pin` always carries the inverse of the true data, so either wrong source choice is visible. A stalled consumer and an enable drop in mid-frame test the hold, replacement and idle rules.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = WORD_W / 2;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        ST_OFF,
        ST_HUNT,
        ST_LEFT,
        ST_RIGHT
    } rx_state_e;

    typedef enum logic [2:0] {
        LEN_32  = 3'd0,
        LEN_24  = 3'd1,
        LEN_20  = 3'd2,
        LEN_18  = 3'd3,
        LEN_16  = 3'd4,
        LEN_P16 = 3'd5,
        LEN_8   = 3'd6,
        LEN_P8  = 3'd7
    } len_code_e;

    function automatic logic [CNT_W-1:0] code_len(input logic [2:0] code);
        unique case (code)
            LEN_32:           return CNT_W'(32);
            LEN_24:           return CNT_W'(24);
            LEN_20:           return CNT_W'(20);
            LEN_18:           return CNT_W'(18);
            LEN_16, LEN_P16:  return CNT_W'(16);
            default:          return CNT_W'(8);
        endcase
    endfunction

    function automatic logic is_packed(input logic [2:0] code);
        return (code == LEN_P16) || (code == LEN_P8);
    endfunction

endpackage

// File: rtl/i2srx_front.sv
module i2srx_front (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic ws,
    input  logic sd_pin,
    input  logic sd_tx,
    input  logic loopback,
    input  logic fmt_lj,
    output logic bit_val,
    output logic slot_start,
    output logic slot_left
);
    logic       ws_d;
    logic       ws_d2;
    logic [1:0] hist;

    always_comb begin
        bit_val = loopback ? sd_tx : sd_pin;
        if (fmt_lj) begin
            slot_start = (hist != 2'd0) && (ws != ws_d);
            slot_left  = ws;
        end else begin
            slot_start = (hist == 2'd2) && (ws_d != ws_d2);
            slot_left  = ~ws_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_d  <= 1'b0;
            ws_d2 <= 1'b0;
            hist  <= 2'd0;
        end else if (bit_stb) begin
            ws_d  <= ws;
            ws_d2 <= ws_d;
            if (hist != 2'd2) hist <= hist + 2'd1;
        end
    end
endmodule

// File: rtl/i2srx_fsm.sv
module i2srx_fsm
    import i2srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              slot_start,
    input  logic              slot_left,
    input  logic [2:0]        len_code,
    input  logic              rx_mono,
    output logic              emit_v,
    output logic [WORD_W-1:0] emit_data,
    output logic              emit_right
);
    rx_state_e         state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  len;
    logic [WORD_W-2:0] sh;
    logic [WORD_W-1:0] hold_left;
    logic [WORD_W-1:0] sample;
    logic [WORD_W-1:0] src;
    logic              in_slot;
    logic              open_slot;
    logic              done;

    always_comb begin
        len       = code_len(len_code);
        in_slot   = (state == ST_LEFT) || (state == ST_RIGHT);
        open_slot = enable && bit_stb && slot_start &&
                    (in_slot || ((state == ST_HUNT) && slot_left));
        done      = enable && bit_stb && !slot_start && in_slot &&
                    (cnt != len) && ((cnt + CNT_W'(1)) == len);
        sample    = {sh, bit_val};
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:  if (enable) nxt = ST_HUNT;
            ST_HUNT, ST_LEFT, ST_RIGHT:
                if (open_slot) nxt = slot_left ? ST_LEFT : ST_RIGHT;
            default: nxt = ST_OFF;
        endcase
        if (!enable) nxt = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            sh        <= '0;
            hold_left <= '0;
        end else begin
            if (open_slot) begin
                cnt <= CNT_W'(1);
                sh  <= {{(WORD_W-2){1'b0}}, bit_val};
            end else if (enable && bit_stb && in_slot && (cnt != len)) begin
                cnt <= cnt + CNT_W'(1);
                sh  <= sample[WORD_W-2:0];
            end
            if (done && (state == ST_LEFT)) hold_left <= sample;
        end
    end

    always_comb begin
        emit_v     = 1'b0;
        emit_data  = '0;
        emit_right = 1'b0;
        src        = rx_mono ? hold_left : sample;
        if (done) begin
            if (state == ST_LEFT) begin
                if (!is_packed(len_code)) begin
                    emit_v    = 1'b1;
                    emit_data = sample;
                end
            end else begin
                emit_v = 1'b1;
                if (len_code == LEN_P16) begin
                    emit_data = {src[HALF_W-1:0], hold_left[HALF_W-1:0]};
                end else if (len_code == LEN_P8) begin
                    emit_data = {{(WORD_W-2*BYTE_W){1'b0}},
                                 src[BYTE_W-1:0], hold_left[BYTE_W-1:0]};
                end else begin
                    emit_data  = src;
                    emit_right = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2srx_outreg.sv
module i2srx_outreg
    import i2srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit_v,
    input  logic [WORD_W-1:0] emit_data,
    input  logic              emit_right,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_right,
    output logic              overrun
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_right <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            overrun <= emit_v && out_valid && !out_ready;
            if (emit_v) begin
                out_valid <= 1'b1;
                out_data  <= emit_data;
                out_right <= emit_right;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
    import i2srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fmt_lj,
    input  logic [2:0]        len_code,
    input  logic              rx_mono,
    input  logic              loopback,
    input  logic              bit_stb,
    input  logic              ws,
    input  logic              sd_pin,
    input  logic              sd_tx,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_right,
    output logic              overrun
);
    logic              bit_val;
    logic              slot_start;
    logic              slot_left;
    logic              emit_v;
    logic [WORD_W-1:0] emit_data;
    logic              emit_right;

    i2srx_front u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .ws         (ws),
        .sd_pin     (sd_pin),
        .sd_tx      (sd_tx),
        .loopback   (loopback),
        .fmt_lj     (fmt_lj),
        .bit_val    (bit_val),
        .slot_start (slot_start),
        .slot_left  (slot_left)
    );

    i2srx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .slot_start (slot_start),
        .slot_left  (slot_left),
        .len_code   (len_code),
        .rx_mono    (rx_mono),
        .emit_v     (emit_v),
        .emit_data  (emit_data),
        .emit_right (emit_right)
    );

    i2srx_outreg u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit_v     (emit_v),
        .emit_data  (emit_data),
        .emit_right (emit_right),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_right  (out_right),
        .overrun    (overrun)
    );
endmodule

// File: rtl/i2srx_checker.sv
module i2srx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic [2:0]  len_code,
    input logic        out_ready,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic        out_right,
    input logic        overrun,
    input logic        emit_v
);
    assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid);

    assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !emit_v |=> $stable(out_data) && $stable(out_right));

    assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(out_valid && !out_ready));

    assert_overrun_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        emit_v && out_valid && !out_ready |=> overrun);

    assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !emit_v);

    assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (len_code == 3'd6) |-> (out_data[31:8] == 24'd0));

    assert_packed8_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (len_code == 3'd7) |-> (out_data[31:16] == 16'd0) && !out_right);
endmodule

bind i2s_rx_deser i2srx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .len_code  (len_code),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_right (out_right),
    .overrun   (overrun),
    .emit_v    (emit_v)
);

// File: tb/tb_i2s_rx_deser.sv
module tb_i2s_rx_deser;
    logic        clk = 1'b0;
    logic        rst_n, enable, fmt_lj, rx_mono, loopback;
    logic [2:0]  len_code;
    logic        bit_stb, ws, sd_pin, sd_tx, out_ready;
    logic        out_valid, out_right, overrun;
    logic [31:0] out_data;

    always #5 clk = ~clk;

    i2s_rx_deser dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fmt_lj(fmt_lj),
        .len_code(len_code), .rx_mono(rx_mono), .loopback(loopback),
        .bit_stb(bit_stb), .ws(ws), .sd_pin(sd_pin), .sd_tx(sd_tx),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_right(out_right), .overrun(overrun)
    );

    typedef struct packed { logic [31:0] d; logic r; } exp_t;
    exp_t  q[$];
    int    n_run = 0;
    int    n_fail = 0;
    int    ovr_cnt = 0;
    logic  prev_b = 1'b0;
    string cur_req = "R11";
    bit    done_flag = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            n_run++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL %s: unexpected word actual %h/%0d expected none",
                         cur_req, out_data, out_right);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (out_data !== e.d || out_right !== e.r) begin
                    n_fail++;
                    $display("FAIL %s: word actual %h/%0d expected %h/%0d",
                             cur_req, out_data, out_right, e.d, e.r);
                end
            end
        end
        if (rst_n && overrun) ovr_cnt++;
    end

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'd0: return 32;
            3'd1: return 24;
            3'd2: return 20;
            3'd3: return 18;
            3'd4, 3'd5: return 16;
            default: return 8;
        endcase
    endfunction

    function automatic logic [31:0] msk(input logic [31:0] v, input int n);
        if (n >= 32) return v;
        return v & ((32'd1 << n) - 32'd1);
    endfunction

    function automatic logic ws_for(input logic left);
        return fmt_lj ? left : ~left;
    endfunction

    task automatic strobe(input logic w, input logic b);
        @(negedge clk);
        ws = w;
        if (loopback) begin sd_tx = b; sd_pin = ~b; end
        else          begin sd_pin = b; sd_tx = ~b; end
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic send_bit(input logic left, input logic b);
        if (fmt_lj) strobe(ws_for(left), b);
        else begin
            strobe(ws_for(left), prev_b);
            prev_b = b;
        end
    endtask

    // excess slot bits driven as ones so discard is visible (R3)
    task automatic send_slot(input logic left, input logic [31:0] v, input int n, input int slot);
        for (int p = 0; p < slot; p++) send_bit(left, (p < n) ? v[n-1-p] : 1'b1);
    endtask

    // two disabled strobes settle history, then a long partial left slot
    // and a partial right slot while enabled: both dropped (R7)
    task automatic start_stream;
        prev_b = 1'b1;
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1);
        @(negedge clk);
        enable = 1'b1;
        for (int i = 0; i < 40; i++) send_bit(1'b1, 1'b1);
        for (int i = 0; i < 5; i++)  send_bit(1'b0, 1'b0);
    endtask

    task automatic configure(input logic f, input logic [2:0] c, input logic m, input logic lb);
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        fmt_lj = f; len_code = c; rx_mono = m; loopback = lb;
    endtask

    task automatic run(input logic f, input logic [2:0] c, input int slot,
                       input logic m, input logic lb, input int nfr, input int seed);
        int n;
        configure(f, c, m, lb);
        out_ready = 1'b1;
        n = len_of(c);
        start_stream();
        for (int fr = 0; fr < nfr; fr++) begin
            logic [31:0] lv, rv, lm, rm, sv;
            lv = 32'h9E37_79B9 * (seed * 7 + fr + 1);
            rv = lv ^ 32'hC3A5_5A3C;
            lm = msk(lv, n);
            rm = msk(rv, n);
            sv = m ? lm : rm;
            if (c == 3'd5)      q.push_back({{sv[15:0], lm[15:0]}, 1'b0});
            else if (c == 3'd7) q.push_back({{16'd0, sv[7:0], lm[7:0]}, 1'b0});
            else begin
                q.push_back({lm, 1'b0});
                q.push_back({sv, 1'b1});
            end
            send_slot(1'b1, lv, n, slot);
            send_slot(1'b0, rv, n, slot);
        end
        if (!fmt_lj) strobe(ws_for(1'b1), prev_b);
        repeat (4) @(negedge clk);
        enable = 1'b0;
        chk({cur_req, " all expected words seen"}, q.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b0; fmt_lj = 1'b1; len_code = 3'd0;
        rx_mono = 1'b0; loopback = 1'b0; bit_stb = 1'b0; ws = 1'b0;
        sd_pin = 1'b0; sd_tx = 1'b0; out_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 out_valid in reset", out_valid, 0);
        chk("R11 overrun in reset", overrun, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 out_valid after reset", out_valid, 0);

        cur_req = "R1 R3 R7 LJ 24-bit";  run(1'b1, 3'd1, 32, 1'b0, 1'b0, 3, 1);
        cur_req = "R2 R3 I2S 16-bit";    run(1'b0, 3'd4, 32, 1'b0, 1'b0, 3, 2);
        cur_req = "R2 I2S 32-bit full slot"; run(1'b0, 3'd0, 32, 1'b0, 1'b0, 2, 3);
        cur_req = "R1 R3 LJ 18-bit";     run(1'b1, 3'd3, 24, 1'b0, 1'b0, 2, 4);
        cur_req = "R2 R3 I2S 20-bit";    run(1'b0, 3'd2, 24, 1'b0, 1'b0, 2, 5);
        cur_req = "R3 LJ 8-bit";         run(1'b1, 3'd6, 16, 1'b0, 1'b0, 2, 6);
        cur_req = "R4 I2S packed 16";    run(1'b0, 3'd5, 16, 1'b0, 1'b0, 3, 7);
        cur_req = "R4 LJ packed 8";      run(1'b1, 3'd7, 8,  1'b0, 1'b0, 3, 8);
        cur_req = "R5 LJ mono 16";       run(1'b1, 3'd4, 16, 1'b1, 1'b0, 2, 9);
        cur_req = "R5 I2S mono packed 8"; run(1'b0, 3'd7, 16, 1'b1, 1'b0, 2, 10);
        cur_req = "R6 I2S loopback 24";  run(1'b0, 3'd1, 32, 1'b0, 1'b1, 2, 11);
        cur_req = "R6 LJ pin path 16";   run(1'b1, 3'd4, 16, 1'b0, 1'b0, 1, 12);
        chk("R9 no overrun with ready consumer", ovr_cnt, 0);

        // R8 / R9: stalled consumer
        cur_req = "R8 R9 stall";
        configure(1'b1, 3'd4, 1'b0, 1'b0);
        out_ready = 1'b0;
        start_stream();
        send_slot(1'b1, 32'h0000_BEEF, 16, 16);
        repeat (3) @(negedge clk);
        chk("R8 held valid", out_valid, 1);
        chk("R8 held data", out_data, 32'h0000_BEEF);
        chk("R8 held channel", out_right, 0);
        send_slot(1'b0, 32'h0000_1234, 16, 16);
        repeat (2) @(negedge clk);
        chk("R9 replaced data", out_data, 32'h0000_1234);
        chk("R9 replaced channel", out_right, 1);
        chk("R9 one overrun pulse", ovr_cnt, 1);
        q.push_back({32'h0000_1234, 1'b1});
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 stalled word delivered", q.size(), 0);
        enable = 1'b0;

        // R10: enable drops mid-frame
        cur_req = "R10 disable";
        configure(1'b1, 3'd4, 1'b0, 1'b0);
        out_ready = 1'b1;
        start_stream();
        q.push_back({32'h0000_A1B2, 1'b0});
        send_slot(1'b1, 32'h0000_A1B2, 16, 16);
        send_bit(1'b0, 1'b1);
        @(negedge clk);
        enable = 1'b0;
        send_slot(1'b0, 32'h0000_7777, 16, 15);
        send_slot(1'b1, 32'h0000_5555, 16, 16);
        send_slot(1'b0, 32'h0000_3333, 16, 16);
        repeat (3) @(negedge clk);
        chk("R10 only pre-disable word", q.size(), 0);
        chk("R10 no word while off", out_valid, 0);
        chk("R9 overrun count unchanged", ovr_cnt, 1);

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule